// File: doc/BRIEF.md
# DPLL Operating Mode Controller

This block decides which operating mode a digital PLL is in and which frequency control word the loop's oscillator should be given. After reset the loop free-runs on a nominal word that stands for the system clock alone. When the reference selector reports a usable reference, the controller enters an acquiring phase and passes the loop's live control word through. It declares lock only after the phase detector's lock indication has stayed high for a programmable number of consecutive cycles.

While locked, the controller keeps a first-order running average of the live control word. That average is the frequency history. Once enough locked samples have been folded into it, the history is marked valid. If the reference then disappears, the controller enters holdover and replays the frozen average. With no valid history it drops back to free-run. A software override can force free-run or holdover at any time, and the override outranks every automatic transition.

The phase detector, the loop filter arithmetic and the oscillator lie outside this block. It only sequences modes and chooses the word to apply.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: While reset is low and in the cycle after its release, mode_o is 0 (free-run), fcw_out_o equals NOMINAL_FCW, and locked_o, holdover_o and hist_valid_o are 0.
- R2: In free-run (mode_o = 0), fcw_out_o equals NOMINAL_FCW whatever fcw_live_i and lock_det_i do. Without an override, the block stays in free-run until ref_valid_i is high.
- R3: With no override, a high ref_valid_i in free-run or holdover moves mode_o to 1 (acquiring) at the next clock edge. In acquiring (1) and locked (2), fcw_out_o follows fcw_live_i.
- R4: The block enters locked (mode_o = 2) only after lock_det_i has been high on LOCK_CYCLES consecutive clock edges spent in acquiring. A single low cycle restarts that count.
- R5: In locked, with ref_valid_i high and no override, a low lock_det_i returns the block to acquiring at the next edge.
- R6: On every clock edge at which the mode is locked, the history is updated from fcw_live_i. The first update after reset loads the word directly. Each later update does acc += (fcw·2^AVG_SHIFT − acc) >>> AVG_SHIFT, where the shift rounds toward minus infinity. The stored word is acc >> AVG_SHIFT. No update happens in any other mode.
- R7: hist_valid_o goes high once MIN_UPDATES history updates have occurred and stays high until reset.
- R8: With no override, a low ref_valid_i in acquiring or locked moves the block to holdover (3) if hist_valid_o is high, and otherwise to free-run (0).
- R9: In holdover, fcw_out_o equals the stored history word and stays constant while fcw_live_i changes.
- R10: mode_ovr_i = 1 forces free-run at the next edge. mode_ovr_i = 2 forces holdover when history is valid and free-run otherwise. Both take priority over ref_valid_i and lock_det_i. Codes 0 and 3 leave the automatic sequencing in control.
- R11: locked_o is high exactly when mode_o = 2, and holdover_o exactly when mode_o = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_valid_i | input | 1 | Selected reference is usable |
| lock_det_i | input | 1 | Phase detector reports lock |
| fcw_live_i | input | FCW_W | Loop's current frequency control word |
| mode_ovr_i | input | 2 | Software override: 0/3 auto, 1 free-run, 2 holdover |
| mode_o | output | 2 | Current mode: 0 free-run, 1 acquiring, 2 locked, 3 holdover |
| fcw_out_o | output | FCW_W | Frequency word to apply |
| locked_o | output | 1 | Mode is locked |
| holdover_o | output | 1 | Mode is holdover |
| hist_valid_o | output | 1 | Frequency history is usable |

## Verification
The bench pulls the reference while the history is still too short, and expects free-run. A design that went to holdover here would replay an unfinished average. It drops lock_det_i for one cycle in the middle of qualification, and expects the count to start again. A design that kept the partial count would declare lock early. It checks the exact floored average after a step in the control word, and then changes the live word during holdover. An off-by-one update, a wrong rounding or a history that was not frozen would all show up as a wrong holdover word. Finally it forces holdover with no history, and forces free-run and holdover while a good reference is present. Either would expose an override that loses to the automatic path.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;

   typedef enum logic [1:0] {
      MODE_FREERUN  = 2'd0,
      MODE_ACQUIRE  = 2'd1,
      MODE_LOCKED   = 2'd2,
      MODE_HOLDOVER = 2'd3
   } dpll_mode_e;

   typedef enum logic [1:0] {
      OVR_AUTO     = 2'd0,
      OVR_FREERUN  = 2'd1,
      OVR_HOLDOVER = 2'd2,
      OVR_AUTO_ALT = 2'd3
   } mode_ovr_e;

endpackage

// File: rtl/dpll_lock_qual.sv
// Counts consecutive lock indications while armed (acquiring).
module dpll_lock_qual #(
   parameter int LOCK_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic lock_det,
   output logic qualified
);
   localparam int CW = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;

   generate
      if (LOCK_CYCLES == 1) begin : g_direct
         assign qualified = arm & lock_det;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         logic          at_last;

         assign at_last   = (cnt_q == CW'(LOCK_CYCLES - 1));
         assign qualified = arm & lock_det & at_last;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!arm || !lock_det || at_last) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dpll_hist_avg.sv
// First-order running average of the control word, updated on request.
module dpll_hist_avg #(
   parameter int FCW_W       = 32,
   parameter int AVG_SHIFT   = 4,
   parameter int MIN_UPDATES = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             update,
   input  logic [FCW_W-1:0] fcw_in,
   output logic [FCW_W-1:0] avg_o,
   output logic             hist_valid_o
);
   localparam int ACC_W = FCW_W + AVG_SHIFT;
   localparam int UCW   = $clog2(MIN_UPDATES + 1);

   logic [UCW-1:0]   upd_cnt_q;
   logic             seeded;
   logic [ACC_W-1:0] acc_q;

   assign seeded       = (upd_cnt_q != '0);
   assign hist_valid_o = (upd_cnt_q == UCW'(MIN_UPDATES));
   assign avg_o        = acc_q[ACC_W-1 -: FCW_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upd_cnt_q <= '0;
      end else if (update && !hist_valid_o) begin
         upd_cnt_q <= upd_cnt_q + 1'b1;
      end
   end

   generate
      if (AVG_SHIFT == 0) begin : g_capture
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc_q <= '0;
            end else if (update) begin
               acc_q <= fcw_in;
            end
         end
      end else begin : g_filter
         logic        [ACC_W-1:0] fcw_ext;
         logic signed [ACC_W:0]   diff;
         logic signed [ACC_W:0]   step;
         logic        [ACC_W-1:0] acc_d;

         assign fcw_ext = {fcw_in, {AVG_SHIFT{1'b0}}};
         assign diff    = $signed({1'b0, fcw_ext}) - $signed({1'b0, acc_q});
         assign step    = diff >>> AVG_SHIFT;
         assign acc_d   = acc_q + step[ACC_W-1:0];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc_q <= '0;
            end else if (update) begin
               acc_q <= seeded ? acc_d : fcw_ext;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dpll_mode_fsm.sv
// Mode sequencing with software override priority.
module dpll_mode_fsm
   import dpll_mode_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_valid,
   input  logic       lock_det,
   input  logic       qualified,
   input  logic       hist_valid,
   input  logic [1:0] ovr,
   output dpll_mode_e mode_q
);
   dpll_mode_e nxt;
   dpll_mode_e fallback;

   assign fallback = hist_valid ? MODE_HOLDOVER : MODE_FREERUN;

   always_comb begin
      nxt = mode_q;
      if (ovr == OVR_FREERUN) begin
         nxt = MODE_FREERUN;
      end else if (ovr == OVR_HOLDOVER) begin
         nxt = fallback;
      end else begin
         unique case (mode_q)
            MODE_FREERUN:  if (ref_valid) nxt = MODE_ACQUIRE;
            MODE_ACQUIRE: begin
               if (!ref_valid)     nxt = fallback;
               else if (qualified) nxt = MODE_LOCKED;
            end
            MODE_LOCKED: begin
               if (!ref_valid)     nxt = fallback;
               else if (!lock_det) nxt = MODE_ACQUIRE;
            end
            MODE_HOLDOVER: if (ref_valid) nxt = MODE_ACQUIRE;
            default:       nxt = MODE_FREERUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_FREERUN;
      else        mode_q <= nxt;
   end

endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
   import dpll_mode_pkg::*;
#(
   parameter int               FCW_W       = 32,
   parameter logic [FCW_W-1:0] NOMINAL_FCW = FCW_W'(1) << (FCW_W - 1),
   parameter int               LOCK_CYCLES = 16,
   parameter int               AVG_SHIFT   = 4,
   parameter int               MIN_UPDATES = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_valid_i,
   input  logic             lock_det_i,
   input  logic [FCW_W-1:0] fcw_live_i,
   input  logic [1:0]       mode_ovr_i,
   output logic [1:0]       mode_o,
   output logic [FCW_W-1:0] fcw_out_o,
   output logic             locked_o,
   output logic             holdover_o,
   output logic             hist_valid_o
);
   generate
      if (FCW_W < 2) begin : g_bad_width
         $error("FCW_W must be at least 2");
      end
      if (LOCK_CYCLES < 1) begin : g_bad_lock
         $error("LOCK_CYCLES must be at least 1");
      end
      if (MIN_UPDATES < 1) begin : g_bad_upd
         $error("MIN_UPDATES must be at least 1");
      end
      if (AVG_SHIFT < 0 || AVG_SHIFT > FCW_W) begin : g_bad_shift
         $error("AVG_SHIFT out of range");
      end
   endgenerate

   dpll_mode_e       mode_q;
   logic             qualified;
   logic [FCW_W-1:0] hist_word;

   dpll_lock_qual #(
      .LOCK_CYCLES(LOCK_CYCLES)
   ) lock_qual_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (mode_q == MODE_ACQUIRE),
      .lock_det (lock_det_i),
      .qualified(qualified)
   );

   dpll_hist_avg #(
      .FCW_W      (FCW_W),
      .AVG_SHIFT  (AVG_SHIFT),
      .MIN_UPDATES(MIN_UPDATES)
   ) hist_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .update      (mode_q == MODE_LOCKED),
      .fcw_in      (fcw_live_i),
      .avg_o       (hist_word),
      .hist_valid_o(hist_valid_o)
   );

   dpll_mode_fsm fsm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_valid (ref_valid_i),
      .lock_det  (lock_det_i),
      .qualified (qualified),
      .hist_valid(hist_valid_o),
      .ovr       (mode_ovr_i),
      .mode_q    (mode_q)
   );

   always_comb begin
      unique case (mode_q)
         MODE_FREERUN:  fcw_out_o = NOMINAL_FCW;
         MODE_HOLDOVER: fcw_out_o = hist_word;
         default:       fcw_out_o = fcw_live_i;
      endcase
   end

   assign mode_o     = mode_q;
   assign locked_o   = (mode_q == MODE_LOCKED);
   assign holdover_o = (mode_q == MODE_HOLDOVER);

endmodule

// File: rtl/dpll_mode_ctrl_chk.sv
module dpll_mode_ctrl_chk #(
   parameter int               FCW_W       = 32,
   parameter logic [FCW_W-1:0] NOMINAL_FCW = '0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ref_valid_i,
   input logic             lock_det_i,
   input logic [1:0]       mode_ovr_i,
   input logic [1:0]       mode_o,
   input logic [FCW_W-1:0] fcw_out_o,
   input logic             locked_o,
   input logic             holdover_o,
   input logic             hist_valid_o
);
   // R2
   freerun_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'd0 && !ref_valid_i && mode_ovr_i != 2'd2) |=> (mode_o == 2'd0));

   // R2
   freerun_nominal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'd0) |-> (fcw_out_o == NOMINAL_FCW));

   // R4
   lock_needs_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'd2 && $past(mode_o) == 2'd1) |-> $past(lock_det_i));

   // R7
   hist_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hist_valid_o) |-> hist_valid_o);

   // R8
   holdover_has_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'd3) |-> hist_valid_o);

   // R9
   holdover_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'd3 && $past(mode_o) == 2'd3) |-> $stable(fcw_out_o));

   // R10
   force_freerun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_ovr_i == 2'd1) |=> (mode_o == 2'd0));

   // R11
   flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({locked_o, holdover_o}));
endmodule

bind dpll_mode_ctrl dpll_mode_ctrl_chk #(
   .FCW_W      (FCW_W),
   .NOMINAL_FCW(NOMINAL_FCW)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .ref_valid_i (ref_valid_i),
   .lock_det_i  (lock_det_i),
   .mode_ovr_i  (mode_ovr_i),
   .mode_o      (mode_o),
   .fcw_out_o   (fcw_out_o),
   .locked_o    (locked_o),
   .holdover_o  (holdover_o),
   .hist_valid_o(hist_valid_o)
);

// File: tb/dpll_mode_ctrl_tb.sv
module dpll_mode_ctrl_tb_top;
   localparam int          FW  = 16;
   localparam logic [15:0] NOM = 16'h8000;
   localparam int          LC  = 4;
   localparam int          SH  = 2;
   localparam int          MU  = 8;
   localparam logic [15:0] LIVE = 16'h1234;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ref_valid = 1'b0;
   logic          lock_det = 1'b0;
   logic [FW-1:0] fcw_live = LIVE;
   logic [1:0]    ovr = 2'd0;
   logic [1:0]    mode;
   logic [FW-1:0] fcw_out;
   logic          locked, holdover, hist_valid;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dpll_mode_ctrl #(
      .FCW_W(FW), .NOMINAL_FCW(NOM), .LOCK_CYCLES(LC),
      .AVG_SHIFT(SH), .MIN_UPDATES(MU)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .ref_valid_i(ref_valid), .lock_det_i(lock_det),
      .fcw_live_i(fcw_live), .mode_ovr_i(ovr), .mode_o(mode), .fcw_out_o(fcw_out),
      .locked_o(locked), .holdover_o(holdover), .hist_valid_o(hist_valid)
   );

   typedef struct packed {
      logic       rv;
      logic       ld;
      logic [1:0] ov;
      logic [7:0] n;
      logic [1:0] md;
      logic       hv;
   } vec_t;

   // mode codes: 0 free-run, 1 acquiring, 2 locked, 3 holdover
   localparam vec_t VEC [25] = '{
      '{1'b0,1'b0,2'd0,8'd3,2'd0,1'b0},
      '{1'b1,1'b0,2'd0,8'd1,2'd1,1'b0},
      '{1'b1,1'b0,2'd0,8'd5,2'd1,1'b0},
      '{1'b1,1'b1,2'd0,8'd3,2'd1,1'b0},
      '{1'b1,1'b1,2'd0,8'd1,2'd2,1'b0},
      '{1'b1,1'b1,2'd0,8'd3,2'd2,1'b0},
      '{1'b0,1'b1,2'd0,8'd1,2'd0,1'b0},
      '{1'b1,1'b1,2'd0,8'd1,2'd1,1'b0},
      '{1'b1,1'b1,2'd0,8'd2,2'd1,1'b0},
      '{1'b1,1'b0,2'd0,8'd1,2'd1,1'b0},
      '{1'b1,1'b1,2'd0,8'd3,2'd1,1'b0},
      '{1'b1,1'b1,2'd0,8'd1,2'd2,1'b0},
      '{1'b1,1'b1,2'd0,8'd5,2'd2,1'b1},
      '{1'b1,1'b0,2'd0,8'd1,2'd1,1'b1},
      '{1'b0,1'b0,2'd0,8'd1,2'd3,1'b1},
      '{1'b0,1'b0,2'd0,8'd4,2'd3,1'b1},
      '{1'b1,1'b1,2'd0,8'd1,2'd1,1'b1},
      '{1'b1,1'b1,2'd0,8'd3,2'd1,1'b1},
      '{1'b1,1'b1,2'd0,8'd1,2'd2,1'b1},
      '{1'b1,1'b1,2'd1,8'd1,2'd0,1'b1},
      '{1'b1,1'b1,2'd1,8'd3,2'd0,1'b1},
      '{1'b1,1'b1,2'd2,8'd1,2'd3,1'b1},
      '{1'b1,1'b1,2'd2,8'd3,2'd3,1'b1},
      '{1'b1,1'b1,2'd3,8'd1,2'd1,1'b1},
      '{1'b0,1'b0,2'd0,8'd1,2'd3,1'b1}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; ref_valid = 1'b0; lock_det = 1'b0; ovr = 2'd0; fcw_live = LIVE;
      step(3);
      rst_n = 1'b1;
   endtask

   function automatic string mode_tag(input logic [1:0] m);
      case (m)
         2'd0:    return "R2 R8 R10 mode";
         2'd1:    return "R3 R4 R5 mode";
         2'd2:    return "R4 mode";
         default: return "R8 R10 mode";
      endcase
   endfunction

   initial begin
      longint acc;
      logic [15:0] held;
      int guard;

      // R1: state during reset and just after release
      step(2);
      check("R1 mode in reset", 32'(mode), 32'd0);
      check("R1 fcw in reset", 32'(fcw_out), 32'(NOM));
      do_reset();
      step(1);
      check("R1 mode after reset", 32'(mode), 32'd0);
      check("R1 flags after reset", {29'd0, locked, holdover, hist_valid}, 32'd0);
      check("R1 fcw after reset", 32'(fcw_out), 32'(NOM));

      // table walk
      for (int i = 0; i < 25; i++) begin
         ref_valid = VEC[i].rv; lock_det = VEC[i].ld; ovr = VEC[i].ov;
         step(int'(VEC[i].n));
         check($sformatf("%s step %0d", mode_tag(VEC[i].md), i), 32'(mode), 32'(VEC[i].md));
         check($sformatf("R7 history step %0d", i), 32'(hist_valid), 32'(VEC[i].hv));
         check($sformatf("R2 R3 R9 fcw step %0d", i), 32'(fcw_out),
               (VEC[i].md == 2'd0) ? 32'(NOM) : 32'(LIVE));
         check($sformatf("R11 flags step %0d", i), {30'd0, locked, holdover},
               {30'd0, VEC[i].md == 2'd2, VEC[i].md == 2'd3});
      end

      // R6 R9: exact average after a step in the word, then frozen in holdover
      do_reset();
      ref_valid = 1'b1; lock_det = 1'b1; fcw_live = 16'h1000;
      guard = 0;
      while (mode != 2'd2 && guard < 20) begin
         step(1);
         guard++;
      end
      check("R4 reached lock", 32'(mode), 32'd2);
      acc = 0;
      for (int k = 0; k < 13; k++) begin
         fcw_live = (k == 0) ? 16'h1000 : 16'h2400;
         if (k == 0) acc = longint'(fcw_live) <<< SH;
         else        acc = acc + (((longint'(fcw_live) <<< SH) - acc) >>> SH);
         if (k == 12) ref_valid = 1'b0;
         step(1);
      end
      held = 16'(acc >>> SH);
      check("R8 holdover after loss", 32'(mode), 32'd3);
      check("R6 R9 holdover word", 32'(fcw_out), 32'(held));
      fcw_live = 16'hFFFF;
      step(5);
      check("R6 R9 holdover frozen", 32'(fcw_out), 32'(held));

      // R10: forced holdover without history yields free-run, even with a reference
      do_reset();
      ovr = 2'd2;
      step(3);
      check("R10 forced holdover no history", 32'(mode), 32'd0);
      ref_valid = 1'b1; lock_det = 1'b1;
      step(6);
      check("R10 override beats reference", 32'(mode), 32'd0);
      check("R2 nominal under override", 32'(fcw_out), 32'(NOM));

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1 actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule